// File: doc/BRIEF.md
# IQ Receive DC-Offset Correction and Sample Gate

This block sits in a two-channel (I and Q) receive baseband path, between the decimation filter and the serial link to the signal processor. Each filtered pair arrives with a valid strobe, at about 270.8 kHz in the target system. The block subtracts a stored per-channel DC offset from the pair and saturates the result. It then decides whether the corrected pair is delivered.

The offsets come from a calibration run. A calibration request, qualified by the path-active condition, starts an accumulation of raw filter output on both channels. The mean is written back into the offset registers. In internal mode the block raises a select that shorts each differential input pair, so only the path's own offset is measured. In external mode the inputs stay connected, and the measured offset includes the external circuitry.

Delivery is gated by power control and by a transmit enable. After every rising edge of the effective enable, the first eight valid pairs are dropped while the filter settles. No pair is delivered while calibration runs.

Top module: `iq_dcoff_gate`

## Requirements
- R1: After reset both offset registers hold zero, `out_valid` and `short_sel` are low, and calibration is idle.
- R2: A delivered pair equals input minus offset on each channel independently. The difference is computed one bit wider and clamped to the signed range [-2^(W-1), 2^(W-1)-1] of `W = SAMPLE_W` bits.
- R3: A rising edge of the qualified calibration request starts a run in the following cycle. Valid pairs are accumulated during the run. On the 16th pair the offset becomes floor(sum/16) per channel and the run ends.
- R4: If the request falls before 16 pairs with n >= 1 taken, the offset becomes floor(mean) of the first 2^k pairs, where k = floor(log2 n). With n = 0 the offsets are unchanged.
- R5: `short_sel` is high for exactly the duration of a run whose mode input `cal_ext` was 0 when it started. It stays low for a run started with `cal_ext` = 1.
- R6: The path is active when `pwr_down` = 0 and either `win_allow` = 0 or `path_on` = 1. While the path is inactive, `cal_req` and `tx_en` have no effect.
- R7: No pair is delivered while a calibration run is in progress, including the cycle that completes it.
- R8: After each rising edge of the effective enable (`tx_en` while the path is active), the first eight valid pairs are dropped. A pair present in the edge cycle counts as the first of them.
- R9: Once eight pairs have been dropped, every valid pair is delivered, with `out_valid` one cycle after `in_valid`.
- R10: While the effective enable is low, nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_on | input | 1 | Receive window control |
| pwr_down | input | 1 | Forces the path inactive |
| win_allow | input | 1 | Lets path_on govern path power |
| cal_req | input | 1 | Calibration request, level |
| cal_ext | input | 1 | 1 = external calibration mode |
| tx_en | input | 1 | Delivery enable |
| in_valid | input | 1 | Filtered pair strobe |
| in_i | input | SAMPLE_W | I sample, two's complement |
| in_q | input | SAMPLE_W | Q sample, two's complement |
| out_valid | output | 1 | Corrected pair strobe |
| out_i | output | SAMPLE_W | Corrected I |
| out_q | output | SAMPLE_W | Corrected Q |
| short_sel | output | 1 | Shorts the differential inputs |

## Verification
Two functions can land on the same cycle.

First, a calibration run can complete on the same clock that a pair arrives while delivery is already settled. The bench keeps the enable high across every run and sends the 16th pair back to back with the others. It expects that pair to be swallowed and the very next pair to come out corrected by the new offset.

Second, the enable edge can coincide with a valid pair. The bench raises `tx_en` on the same cycle as a pair. It requires exactly eight silent pairs counted from that one, then the ninth pair delivered. It repeats this after an enable drop and after a power cycle, to show the drop count restarts at each edge.

// File: rtl/iq_dcoff_pkg.sv
package iq_dcoff_pkg;

  function automatic bit is_pow2(input int x);
    return (x > 0) && ((x & (x - 1)) == 0);
  endfunction

  function automatic int floor_log2(input int x);
    int r;
    r = 0;
    for (int b = 0; b < 31; b++) begin
      if ((x >> b) != 0) r = b;
    end
    return r;
  endfunction

endpackage

// File: rtl/iq_cal_seq.sv
module iq_cal_seq #(
  parameter int CAL_LOG2 = 4,
  localparam int CNT_W = CAL_LOG2 + 1,
  localparam int SH_W  = (CAL_LOG2 < 1) ? 1 : $clog2(CAL_LOG2 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_go,
  input  logic            cal_ext,
  input  logic            in_valid,
  output logic            busy,
  output logic            acc_clr,
  output logic            acc_en,
  output logic            snap_en,
  output logic [SH_W-1:0] snap_sh,
  output logic            commit_full,
  output logic            commit_part,
  output logic            short_sel
);
  import iq_dcoff_pkg::*;

  localparam logic [CNT_W-1:0] RUN_LEN = CNT_W'(1 << CAL_LOG2);

  logic             go_d;
  logic             ext_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             abort;

  assign acc_clr     = cal_go && !go_d && !busy;
  assign acc_en      = busy && cal_go && in_valid;
  assign cnt_nxt     = cnt + CNT_W'(1);
  assign commit_full = acc_en && (cnt_nxt == RUN_LEN);
  assign abort       = busy && !cal_go;
  assign commit_part = abort && (cnt != '0);
  assign snap_en     = acc_en && is_pow2(int'(cnt_nxt));
  assign short_sel   = busy && !ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_d    <= 1'b0;
      busy    <= 1'b0;
      ext_q   <= 1'b0;
      cnt     <= '0;
      snap_sh <= '0;
    end else begin
      go_d <= cal_go;
      if (acc_clr) begin
        busy  <= 1'b1;
        ext_q <= cal_ext;
        cnt   <= '0;
      end else if (commit_full || abort) begin
        busy <= 1'b0;
      end else if (acc_en) begin
        cnt <= cnt_nxt;
      end
      if (acc_clr)      snap_sh <= '0;
      else if (snap_en) snap_sh <= SH_W'(floor_log2(int'(cnt_nxt)));
    end
  end

endmodule

// File: rtl/dcoff_chan.sv
module dcoff_chan #(
  parameter int W        = 12,
  parameter int CAL_LOG2 = 4,
  localparam int ACC_W   = W + CAL_LOG2,
  localparam int SH_W    = (CAL_LOG2 < 1) ? 1 : $clog2(CAL_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] sample,
  input  logic                acc_clr,
  input  logic                acc_en,
  input  logic                snap_en,
  input  logic [SH_W-1:0]     snap_sh,
  input  logic                commit_full,
  input  logic                commit_part,
  output logic signed [W-1:0] offset
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] snap;
  logic signed [ACC_W-1:0] sum_nxt;
  logic signed [ACC_W-1:0] full_mean;
  logic signed [ACC_W-1:0] part_mean;

  assign sum_nxt   = acc + {{CAL_LOG2{sample[W-1]}}, sample};
  assign full_mean = sum_nxt >>> CAL_LOG2;
  assign part_mean = snap >>> snap_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      snap   <= '0;
      offset <= '0;
    end else begin
      if (acc_clr)     acc <= '0;
      else if (acc_en) acc <= sum_nxt;
      if (acc_clr)      snap <= '0;
      else if (snap_en) snap <= sum_nxt;
      if (commit_full)      offset <= full_mean[W-1:0];
      else if (commit_part) offset <= part_mean[W-1:0];
    end
  end

endmodule

// File: rtl/iq_tx_gate.sv
module iq_tx_gate #(
  parameter int SETTLE_N = 8,
  localparam int DW = $clog2(SETTLE_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic path_on,
  input  logic pwr_down,
  input  logic win_allow,
  input  logic tx_en,
  input  logic in_valid,
  input  logic cal_busy,
  output logic path_act,
  output logic tx_rise,
  output logic fwd
);
  logic          tx_go;
  logic          tx_go_d;
  logic [DW-1:0] drop_cnt;
  logic [DW-1:0] cnt_eff;
  logic          settled;

  assign path_act = !pwr_down && (!win_allow || path_on);
  assign tx_go    = tx_en && path_act;
  assign tx_rise  = tx_go && !tx_go_d;
  assign cnt_eff  = tx_rise ? '0 : drop_cnt;
  assign settled  = (cnt_eff == DW'(SETTLE_N));
  assign fwd      = tx_go && in_valid && settled && !cal_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_go_d  <= 1'b0;
      drop_cnt <= '0;
    end else begin
      tx_go_d <= tx_go;
      if (tx_go && in_valid && !settled) drop_cnt <= cnt_eff + DW'(1);
      else if (tx_rise)                  drop_cnt <= '0;
    end
  end

endmodule

// File: rtl/iq_dcoff_gate.sv
module iq_dcoff_gate #(
  parameter int SAMPLE_W = 12,
  parameter int CAL_LOG2 = 4,
  parameter int SETTLE_N = 8,
  localparam int SH_W    = (CAL_LOG2 < 1) ? 1 : $clog2(CAL_LOG2 + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       path_on,
  input  logic                       pwr_down,
  input  logic                       win_allow,
  input  logic                       cal_req,
  input  logic                       cal_ext,
  input  logic                       tx_en,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q,
  output logic                       short_sel
);
  localparam int NCH = 2;

  function automatic logic signed [SAMPLE_W-1:0] sat_sub(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b);
    logic signed [SAMPLE_W:0] d;
    d = {a[SAMPLE_W-1], a} - {b[SAMPLE_W-1], b};
    if (d[SAMPLE_W] != d[SAMPLE_W-1])
      return d[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}} : {1'b0, {(SAMPLE_W-1){1'b1}}};
    return d[SAMPLE_W-1:0];
  endfunction

  logic            path_act;
  logic            tx_rise;
  logic            fwd;
  logic            cal_go;
  logic            cal_busy;
  logic            acc_clr;
  logic            acc_en;
  logic            snap_en;
  logic [SH_W-1:0] snap_sh;
  logic            commit_full;
  logic            commit_part;
  logic            commit_any;
  logic signed [SAMPLE_W-1:0] smp [NCH];
  logic signed [SAMPLE_W-1:0] off [NCH];
  logic signed [SAMPLE_W-1:0] off_i;
  logic signed [SAMPLE_W-1:0] off_q;

  assign cal_go     = cal_req && path_act;
  assign commit_any = commit_full || commit_part;
  assign smp[0]     = in_i;
  assign smp[1]     = in_q;
  assign off_i      = off[0];
  assign off_q      = off[1];

  iq_tx_gate #(.SETTLE_N(SETTLE_N)) u_gate (
    .clk(clk), .rst_n(rst_n), .path_on(path_on), .pwr_down(pwr_down),
    .win_allow(win_allow), .tx_en(tx_en), .in_valid(in_valid),
    .cal_busy(cal_busy), .path_act(path_act), .tx_rise(tx_rise), .fwd(fwd)
  );

  iq_cal_seq #(.CAL_LOG2(CAL_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .cal_go(cal_go), .cal_ext(cal_ext),
    .in_valid(in_valid), .busy(cal_busy), .acc_clr(acc_clr), .acc_en(acc_en),
    .snap_en(snap_en), .snap_sh(snap_sh), .commit_full(commit_full),
    .commit_part(commit_part), .short_sel(short_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dcoff_chan #(.W(SAMPLE_W), .CAL_LOG2(CAL_LOG2)) u_chan (
      .clk(clk), .rst_n(rst_n), .sample(smp[c]), .acc_clr(acc_clr),
      .acc_en(acc_en), .snap_en(snap_en), .snap_sh(snap_sh),
      .commit_full(commit_full), .commit_part(commit_part), .offset(off[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= fwd;
      if (fwd) begin
        out_i <= sat_sub(in_i, off_i);
        out_q <= sat_sub(in_q, off_q);
      end
    end
  end

endmodule

// File: rtl/iq_dcoff_gate_chk.sv
module iq_dcoff_gate_chk #(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                path_act,
  input logic                cal_busy,
  input logic                short_sel,
  input logic                commit_any,
  input logic                tx_rise,
  input logic signed [W-1:0] off_i,
  input logic signed [W-1:0] off_q
);
  a_r4_offset_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit_any) |-> ($stable(off_i) && $stable(off_q)));

  a_r7_no_out_during_cal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(cal_busy));

  a_r6_out_needs_path: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(path_act));

  a_r5_short_within_run: assert property (@(posedge clk) disable iff (!rst_n)
    short_sel |-> cal_busy);

  a_r3_commit_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    commit_any |=> !cal_busy);

  a_r8_edge_pair_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rise |=> !out_valid);
endmodule

bind iq_dcoff_gate iq_dcoff_gate_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .path_act(path_act),
  .cal_busy(cal_busy), .short_sel(short_sel), .commit_any(commit_any),
  .tx_rise(tx_rise), .off_i(off_i), .off_q(off_q)
);

// File: tb/iq_dcoff_gate_bench.sv
module iq_dcoff_gate_bench;
  localparam int W    = 12;
  localparam int MAXV = 2047;
  localparam int MINV = -2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic path_on = 1'b0, pwr_down = 1'b0, win_allow = 1'b1;
  logic cal_req = 1'b0, cal_ext = 1'b0, tx_en = 1'b0, in_valid = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0;
  logic out_valid, short_sel;
  logic signed [W-1:0] out_i, out_q;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  int oi = 0, oq = 0;
  int si, sq;

  always #2 clk = ~clk;

  iq_dcoff_gate u_iq_dcoff_gate (
    .clk(clk), .rst_n(rst_n), .path_on(path_on), .pwr_down(pwr_down),
    .win_allow(win_allow), .cal_req(cal_req), .cal_ext(cal_ext), .tx_en(tx_en),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .short_sel(short_sel)
  );

  function automatic int clamp(input int d);
    if (d > MAXV) return MAXV;
    if (d < MINV) return MINV;
    return d;
  endfunction

  function automatic int fdiv(input int s, input int d);
    int q;
    q = s / d;
    if ((s % d) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  task automatic bit_check(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send(input int vi, input int vq, input bit exp_v, input string req);
    int ei, eq;
    ei = clamp(vi - oi);
    eq = clamp(vq - oq);
    in_i = W'(vi);
    in_q = W'(vq);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    nvec++;
    if (out_valid !== exp_v ||
        (exp_v && (int'(out_i) != ei || int'(out_q) != eq))) begin
      nfail++;
      $display("FAIL %s: got v=%0b i=%0d q=%0d expected v=%0b i=%0d q=%0d",
               req, out_valid, out_i, out_q, exp_v, ei, eq);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    for (int v = MINV; v <= MAXV; v += 37) send(v, -v - 1, 1'b1, req);
    send(MAXV, MINV, 1'b1, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    bit_check("R1 out_valid in reset", out_valid, 1'b0);
    bit_check("R1 short_sel in reset", short_sel, 1'b0);
    rst_n = 1'b1;
    path_on = 1'b1;
    idle(2);
    bit_check("R1 out_valid after reset", out_valid, 1'b0);

    // R8: edge coincides with a pair; eight dropped, then R9 and R1 zero offset
    tx_en = 1'b1;
    for (int k = 0; k < 8; k++) send(k, -k, 1'b0, "R8 settle drop");
    sweep("R1 R9 zero-offset pass");

    // R3 R5 R7: internal full run while enable stays high
    cal_ext = 1'b0;
    cal_req = 1'b1;
    idle(1);
    bit_check("R5 short in internal run", short_sel, 1'b1);
    si = 0; sq = 0;
    for (int k = 0; k < 16; k++) begin
      si += 100 + 3 * k;
      sq += -50 - k;
      send(100 + 3 * k, -50 - k, 1'b0, "R7 no output in run");
    end
    bit_check("R3 run ended after 16", short_sel, 1'b0);
    oi = fdiv(si, 16);
    oq = fdiv(sq, 16);
    send(500, -500, 1'b1, "R3 R7 first pair after run");
    cal_req = 1'b0;
    idle(1);
    sweep("R2 R3 corrected sweep");

    // R2 saturation with large offsets
    cal_req = 1'b1;
    idle(1);
    for (int k = 0; k < 16; k++) send(2000, -2000, 1'b0, "R7 no output in run");
    cal_req = 1'b0;
    idle(1);
    oi = 2000; oq = -2000;
    send(MINV, MAXV, 1'b1, "R2 saturate both ways");
    send(MAXV, MINV, 1'b1, "R2 near limits");
    send(0, 0, 1'b1, "R2 zero input");
    sweep("R2 saturating sweep");

    // R4 R5: external early stop after 5 pairs uses first 4
    cal_ext = 1'b1;
    cal_req = 1'b1;
    idle(1);
    bit_check("R5 no short in external run", short_sel, 1'b0);
    send(-3, 7, 1'b0, "R7 no output in run");
    send(-4, 8, 1'b0, "R7 no output in run");
    send(-4, 8, 1'b0, "R7 no output in run");
    send(-4, 9, 1'b0, "R7 no output in run");
    send(100, -100, 1'b0, "R7 no output in run");
    cal_req = 1'b0;
    idle(1);
    oi = fdiv(-15, 4);
    oq = fdiv(32, 4);
    sweep("R4 early-stop mean");

    // R4: stop with zero pairs leaves offsets unchanged
    cal_req = 1'b1;
    idle(2);
    cal_req = 1'b0;
    idle(1);
    send(10, -10, 1'b1, "R4 zero-pair stop unchanged");
    // R4: one pair
    cal_ext = 1'b0;
    cal_req = 1'b1;
    idle(1);
    send(77, -5, 1'b0, "R7 no output in run");
    cal_req = 1'b0;
    idle(1);
    oi = 77; oq = -5;
    send(300, 300, 1'b1, "R4 single-pair stop");

    // R6: window control holds path inactive
    path_on = 1'b0;
    send(1, 2, 1'b0, "R6 path off no output");
    send(3, 4, 1'b0, "R6 path off no output");
    cal_req = 1'b1;
    idle(2);
    bit_check("R6 cal ignored when off", short_sel, 1'b0);
    cal_req = 1'b0;
    idle(1);
    send(5, 6, 1'b0, "R6 path off no output");
    // window not allowed: path active regardless, new edge
    win_allow = 1'b0;
    for (int k = 0; k < 8; k++) send(k, k, 1'b0, "R6 R8 drop after power-up");
    send(400, -400, 1'b1, "R6 R9 delivered after settle");
    pwr_down = 1'b1;
    send(1, 1, 1'b0, "R6 power-down blocks");
    pwr_down = 1'b0;
    for (int k = 0; k < 8; k++) send(k, k, 1'b0, "R8 drop after power-down");
    send(-400, 400, 1'b1, "R9 delivered after settle");

    // R10 then R8 restart after partial drop
    tx_en = 1'b0;
    send(9, 9, 1'b0, "R10 enable low no output");
    tx_en = 1'b1;
    for (int k = 0; k < 3; k++) send(k, k, 1'b0, "R8 partial drop");
    tx_en = 1'b0;
    idle(1);
    tx_en = 1'b1;
    for (int k = 0; k < 8; k++) send(k, k, 1'b0, "R8 restart drop");
    send(123, -321, 1'b1, "R9 after restart");
    tx_en = 1'b0;
    send(9, 9, 1'b0, "R10 enable low no output");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule